// File: doc/BRIEF.md
# Timed Sleep Controller with Chip-Select Wake

The block keeps a device in a timed shutdown. Software writes a 16-bit word; its low byte is a count of half-second units. A nonzero count puts the block to sleep on the next cycle. It then holds `sleep_active` high for exactly that many half-seconds and returns to normal operation by itself. While the block sleeps, the active-low chip select `cs_n` must stay high. Pulling it low ends the sleep at once.

A free-running prescaler, enabled only while the block sleeps, turns the system clock into a half-second tick. The parameter `CLK_HZ` sets the clock, and one unit lasts `CLK_HZ/2` cycles. The remaining count is visible on `rd_count`. Every exit from sleep, whether by timeout or by chip select, is marked by a one-cycle `wake_pulse`, and the count reads zero from that cycle on.

The controller has three states:
- AWAKE is normal operation.
- SLEEP is the timed shutdown.
- RESUME is a single cycle that flags the exit.

Its transitions are:
- AWAKE→SLEEP on a nonzero write.
- SLEEP→RESUME on the last unit tick or on a synchronised chip-select low.
- RESUME→SLEEP on a nonzero write in that cycle.
- RESUME→AWAKE otherwise.

Top module: `sleep_timer_ctrl`

## Requirements
- R1: During and right after reset, `sleep_active` and `wake_pulse` are 0 and `rd_count` is 0.
- R2: In AWAKE, a write (`wr_en` high) whose bits 7:0 are nonzero raises `sleep_active` on the next cycle, and `rd_count` then shows those bits.
- R3: A write whose bits 7:0 are zero does not start a sleep. Bits 15:8 of a write are ignored, and `rd_count[15:8]` always reads 0.
- R4: Without a chip-select wake, `sleep_active` stays high for exactly N × `CLK_HZ/2` cycles, where N is the written count. For example, a count of 6 gives 3 s.
- R5: While the block sleeps, `rd_count` drops by one at each half-second boundary. At the j-th sleeping cycle it reads N − floor((j−1)/(`CLK_HZ/2`)).
- R6: `cs_n` is synchronised by two flops. If `cs_n` goes low while the block sleeps, `sleep_active` is low from the third cycle after the change.
- R7: Each exit from sleep produces `wake_pulse` high for exactly one cycle. That cycle is the first one with `sleep_active` low, and `rd_count` is 0 in it.
- R8: `cs_n` held high keeps the sleep going. A low `cs_n` while the block is awake has no effect on either output.
- R9: Writes that arrive while the block sleeps are ignored. They change neither the count nor the sleep length.
- R10: If the chip-select wake and the final timeout tick fall on the same cycle, the block still exits once, with a single wake pulse and a sleep of N units.
- R11: A nonzero write in the RESUME cycle starts a new sleep on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_HZ` Hz |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the sleep-count word |
| wr_data | input | 16 | Write data; bits 7:0 hold the count in 0.5 s units |
| cs_n | input | 1 | Active-low chip select; low wakes the block |
| rd_count | output | 16 | Remaining sleep count, zero-extended |
| sleep_active | output | 1 | High while the block sleeps |
| wake_pulse | output | 1 | One-cycle pulse when a sleep ends |

## Verification
Two functions can fall in the same cycle: the early wake from chip select and the expiry of the last half-second unit. Both lead from SLEEP to RESUME. The bench drops `cs_n` at a series of offsets just before the final tick, so that the synchronised low lands two cycles early, one cycle early, on the tick itself and after it. Each case is judged against a bench function giving the expected sleep length as the smaller of the chip-select exit and the timeout. In every case the bench also checks that exactly one wake pulse appears and that the count reads zero with it.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

    localparam int REG_W = 16;
    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_RESUME = 2'd2
    } slp_state_e;

endpackage

// File: rtl/slp_sync2.sv
module slp_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/slp_unit_tick.sv
module slp_unit_tick #(
    parameter int UNIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int PRE_W = (UNIT_CYCLES > 2) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(UNIT_CYCLES - 1);

    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (clear) begin
            pre <= '0;
        end else if (run) begin
            if (pre == LAST) pre <= '0;
            else             pre <= pre + 1'b1;
        end
    end

    assign tick = run && (pre == LAST);
endmodule

// File: rtl/slp_count.sv
module slp_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic         clear,
    output logic [W-1:0] count,
    output logic         last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (clear)  count <= '0;
        else if (load)   count <= load_val;
        else if (dec)    count <= count - 1'b1;
    end

    assign last = (count == W'(1));
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import sleep_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_start,
    input  logic cs_low,
    input  logic tick,
    input  logic last,
    output logic cnt_load,
    output logic cnt_dec,
    output logic cnt_clear,
    output logic pre_run,
    output logic pre_clear,
    output logic sleep_active,
    output logic wake_pulse
);
    slp_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_AWAKE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_AWAKE:  if (wr_start) state_nx = ST_SLEEP;
            ST_SLEEP:  if (cs_low || (tick && last)) state_nx = ST_RESUME;
            ST_RESUME: state_nx = wr_start ? ST_SLEEP : ST_AWAKE;
            default:   state_nx = ST_AWAKE;
        endcase
    end

    always_comb begin
        cnt_load     = 1'b0;
        cnt_dec      = 1'b0;
        cnt_clear    = 1'b0;
        pre_run      = 1'b0;
        pre_clear    = 1'b0;
        sleep_active = 1'b0;
        wake_pulse   = 1'b0;
        unique case (state)
            ST_AWAKE: begin
                cnt_load  = wr_start;
                pre_clear = wr_start;
            end
            ST_SLEEP: begin
                sleep_active = 1'b1;
                pre_run      = 1'b1;
                cnt_clear    = cs_low || (tick && last);
                cnt_dec      = tick && !last && !cs_low;
            end
            ST_RESUME: begin
                wake_pulse = 1'b1;
                cnt_load   = wr_start;
                pre_clear  = wr_start;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sleep_timer_ctrl.sv
module sleep_timer_ctrl
    import sleep_ctrl_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             cs_n,
    output logic [REG_W-1:0] rd_count,
    output logic             sleep_active,
    output logic             wake_pulse
);
    localparam int UNIT_CYCLES = (CLK_HZ / 2 > 1) ? CLK_HZ / 2 : 2;

    logic             cs_n_sync;
    logic             wr_start;
    logic             tick, last;
    logic             cnt_load, cnt_dec, cnt_clear;
    logic             pre_run, pre_clear;
    logic [CNT_W-1:0] count;

    assign wr_start = wr_en && (wr_data[CNT_W-1:0] != '0);

    slp_sync2 #(.RST_VAL(1'b1)) u_cs_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cs_n),
        .q     (cs_n_sync)
    );

    slp_unit_tick #(.UNIT_CYCLES(UNIT_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pre_run),
        .clear (pre_clear),
        .tick  (tick)
    );

    slp_count #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (wr_data[CNT_W-1:0]),
        .dec      (cnt_dec),
        .clear    (cnt_clear),
        .count    (count),
        .last     (last)
    );

    slp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_start     (wr_start),
        .cs_low       (!cs_n_sync),
        .tick         (tick),
        .last         (last),
        .cnt_load     (cnt_load),
        .cnt_dec      (cnt_dec),
        .cnt_clear    (cnt_clear),
        .pre_run      (pre_run),
        .pre_clear    (pre_clear),
        .sleep_active (sleep_active),
        .wake_pulse   (wake_pulse)
    );

    assign rd_count = {{(REG_W-CNT_W){1'b0}}, count};
endmodule

// File: rtl/slp_ctrl_checker.sv
module slp_ctrl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic        cs_n,
    input logic [15:0] rd_count,
    input logic        sleep_active,
    input logic        wake_pulse
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:0] != 8'd0 && !sleep_active)
        |=> (sleep_active && rd_count[7:0] == $past(wr_data[7:0])));

    assert_zero_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:0] == 8'd0 && !sleep_active) |=> !sleep_active);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active && $past(sleep_active))
        |-> (rd_count == $past(rd_count) || rd_count == $past(rd_count) - 16'd1));

    assert_early_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && sleep_active && !$past(cs_n, 2)) |=> !sleep_active);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && sleep_active && rd_count > 16'd1 && $past(cs_n, 2))
        |=> sleep_active);

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_pulse_after_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(sleep_active) && !sleep_active && rd_count == 16'd0));

    assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active && wr_en) |=> (rd_count <= $past(rd_count)));
endmodule

bind sleep_timer_ctrl slp_ctrl_checker u_slp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .cs_n         (cs_n),
    .rd_count     (rd_count),
    .sleep_active (sleep_active),
    .wake_pulse   (wake_pulse)
);

// File: tb/sleep_timer_ctrl_bench.sv
module sleep_timer_ctrl_bench;
    localparam int CLK_HZ = 80;
    localparam int UNIT   = CLK_HZ / 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] wr_data;
    logic        cs_n;
    logic [15:0] rd_count;
    logic        sleep_active;
    logic        wake_pulse;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    sleep_timer_ctrl #(.CLK_HZ(CLK_HZ)) u_sleep_timer_ctrl (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .cs_n (cs_n), .rd_count (rd_count), .sleep_active (sleep_active),
        .wake_pulse (wake_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int n, input int wake_at);
        int full = n * UNIT;
        if (wake_at == 0) return full;
        return (wake_at + 2 < full) ? wake_at + 2 : full;
    endfunction

    // Issues a write, follows the sleep to its end; returns at the first awake sample.
    task automatic run_sleep(input logic [15:0] data, input int wake_at,
                             input bit noise, output int len);
        int n   = int'(data[7:0]);
        int exl = exp_len(n, wake_at);
        int j   = 0;
        wr_en = 1'b1; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        while (sleep_active && j < 3000) begin
            j++;
            check(int'(rd_count) == n - (j - 1) / UNIT, "R5 count", int'(rd_count), n - (j - 1) / UNIT);
            if (j == wake_at) cs_n = 1'b0;
            if (noise && j < exl - 2 && ($urandom % 4) == 0) begin
                wr_en = 1'b1; wr_data = 16'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        len = j;
        check(wake_pulse == 1'b1, "R7 pulse at exit", int'(wake_pulse), 1);
        check(rd_count == 16'd0, "R7 count zero", int'(rd_count), 0);
    endtask

    task automatic finish_exit();
        @(negedge clk);
        check(wake_pulse == 1'b0, "R7 pulse one cycle", int'(wake_pulse), 0);
        check(sleep_active == 1'b0, "R7 awake", int'(sleep_active), 0);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int len;
        void'($urandom(32'd2718));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!sleep_active && !wake_pulse && rd_count == 0, "R1 in reset", int'(rd_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sleep_active && !wake_pulse && rd_count == 0, "R1 after reset", int'(sleep_active), 0);

        // R3: zero count, upper byte only
        wr_en = 1'b1; wr_data = 16'h0000; @(negedge clk);
        wr_data = 16'hAB00; @(negedge clk); wr_en = 1'b0;
        repeat (3) begin
            check(!sleep_active && !wake_pulse, "R3 zero write ignored", int'(sleep_active), 0);
            @(negedge clk);
        end

        // R8: chip select low while awake
        cs_n = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check(!sleep_active && !wake_pulse, "R8 cs while awake", int'(wake_pulse), 0);
        end
        cs_n = 1'b1; repeat (3) @(negedge clk);

        // R2/R4: count of 6 -> 3 s
        wr_en = 1'b1; wr_data = 16'h0006; @(negedge clk); wr_en = 1'b0;
        check(sleep_active && rd_count == 6, "R2 enter sleep", int'(rd_count), 6);
        len = 1;
        while (sleep_active && len < 1000) begin @(negedge clk); if (sleep_active) len++; end
        check(len == 6 * UNIT, "R4 six units", len, 6 * UNIT);
        check(wake_pulse == 1'b1, "R7 pulse after timeout", int'(wake_pulse), 1);
        finish_exit();

        // R3: upper byte ignored on load
        run_sleep(16'hFF03, 0, 1'b0, len);
        check(len == 3 * UNIT, "R3 upper bits ignored", len, 3 * UNIT);
        finish_exit();

        // R9: writes during sleep
        run_sleep(16'h0002, 0, 1'b1, len);
        check(len == 2 * UNIT, "R9 writes ignored", len, 2 * UNIT);
        finish_exit();

        // R6: early wake
        run_sleep(16'h0005, 10, 1'b0, len);
        check(len == 12, "R6 early wake", len, 12);
        finish_exit();

        // R10: wake coinciding with final tick
        for (int s = UNIT - 4; s <= UNIT; s++) begin
            run_sleep(16'h0001, s, 1'b0, len);
            check(len == exp_len(1, s), "R10 coincident exit", len, exp_len(1, s));
            finish_exit();
        end

        // R11: write during resume cycle
        run_sleep(16'h0001, 0, 1'b0, len);
        wr_en = 1'b1; wr_data = 16'h0002; @(negedge clk); wr_en = 1'b0;
        check(sleep_active && rd_count == 2, "R11 resume write", int'(rd_count), 2);
        cs_n = 1'b0;
        len = 0;
        while (sleep_active && len < 10) begin @(negedge clk); len++; end
        check(len == 3, "R6 wake after resume write", len, 3);
        finish_exit();

        // Random mix
        for (int t = 0; t < 30; t++) begin
            int n  = 1 + int'($urandom % 4);
            int wa = (($urandom % 2) == 0) ? 0 : 1 + int'($urandom % (n * UNIT + 4));
            logic [15:0] d = {8'($urandom), 8'(n)};
            run_sleep(d, wa, 1'b1, len);
            check(len == exp_len(n, wa), "R4 random length", len, exp_len(n, wa));
            finish_exit();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule